// File: doc/BRIEF.md
# I/O Permission Bitmap Checker

This block decides whether an I/O access of one, two or four bytes at a 16-bit port number may proceed, based on the I/O permission bitmap of the task that is currently active. When a task is made active, the block is given the base address and byte limit of that task's state segment. For a segment in the 32-bit format, the block fetches the bitmap offset word from the segment and derives two values from it: a bitmap address and a bitmap byte limit. For a segment in the 16-bit format, the bitmap limit is simply cleared.

When a check is requested, the block first validates the access length. It then tests whether the highest bitmap byte the access could touch lies inside the bitmap. If both tests pass, it reads one 16-bit bitmap word through its memory read port and tests the bits covered by the access. The verdict is either allow or a general-protection fault with error code zero. It is delivered as a one-cycle done pulse. Because a 16-bit word is fetched, an access whose bits spill into the next bitmap byte is still resolved with a single read and a single mask.

The memory port holds a request and its address steady until the read data returns with a valid strobe. Requests and task loads are taken only while the block is idle.

Top module: `iopb_checker`

## Requirements
- R1: After reset, ready_o is 1, done_o and mem_req_o are 0, and the bitmap limit is 0, so a check with a legal length faults without a memory read.
- R2: A task load with ld_wide_i=1 issues exactly one memory read, at address ld_base_i + 102. The 16-bit result is taken as the bitmap offset. A later read returns bits 7:0 from the byte at the lower address.
- R3: If that offset is nonzero and below ld_limit_i, the bitmap limit becomes the low 16 bits of (ld_limit_i − offset) and the bitmap address becomes ld_base_i + offset.
- R4: If the offset is zero, or is equal to or greater than ld_limit_i, the bitmap limit becomes 0 and every legal check faults.
- R5: A task load with ld_wide_i=0 issues no memory read and sets the bitmap limit to 0.
- R6: A check whose chk_len_i is not 1, 2 or 4 ends one cycle later with done_o and req_err_o, and issues no memory read.
- R7: A legal check where (chk_port_i + chk_len_i) / 8, computed without overflow, is at least the bitmap limit faults one cycle after the request and issues no memory read.
- R8: Otherwise one memory read is issued, at bitmap address + chk_port_i / 8. Its address stays stable until mem_rvalid_i.
- R9: The mask is ((1 << chk_len_i) − 1) shifted left by chk_port_i mod 8, applied to the 16-bit word that was read. Any masked bit set gives fault_o; none set gives allow_o. The result appears one cycle after mem_rvalid_i.
- R10: done_o comes with exactly one of allow_o, fault_o, req_err_o; none of the three is high without done_o.
- R11: While ready_o is 0, chk_req_i and ld_req_i are ignored. If both arrive together while idle, the load is taken and the check is dropped.
- R12: err_code_o is zero whenever fault_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ld_req_i | input | 1 | Make a new task active (one-cycle pulse) |
| ld_wide_i | input | 1 | 1: 32-bit state segment, 0: 16-bit |
| ld_base_i | input | 32 | State segment base address |
| ld_limit_i | input | 32 | State segment byte limit |
| chk_req_i | input | 1 | Check request (one-cycle pulse) |
| chk_port_i | input | 16 | Port number to check |
| chk_len_i | input | 3 | Access length in bytes |
| ready_o | output | 1 | Idle, request or load accepted |
| done_o | output | 1 | Result pulse |
| allow_o | output | 1 | Access permitted |
| fault_o | output | 1 | General-protection fault |
| req_err_o | output | 1 | Illegal length |
| err_code_o | output | 16 | Fault error code |
| mem_req_o | output | 1 | Memory read pending |
| mem_addr_o | output | 32 | Memory read byte address |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 16 | Read data, lower-address byte in bits 7:0 |

## Verification
The hardest cases to reach from the ports sit at the limit edge. One is an access whose last byte index equals the bitmap limit. Another is a port near 65535, where the port plus length overflows 16 bits. A third is a segment limit large enough that the subtracted bitmap limit wraps to a small 16-bit value. The stimulus reaches them by loading tasks whose offset and limit are chosen so that the derived limit is small and known, then probing ports one below and at the boundary. A masked bit that lands in the second byte of the fetched word is also forced, by placing denial bits at the start of the next bitmap byte. Requests and loads are also pulsed while a read is outstanding, and together in the same idle cycle, and the bench confirms that no extra result appears and that the loaded state survives.

// File: rtl/iopb_pkg.sv
package iopb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_LD_WAIT = 2'd1,
    ST_CK_WAIT = 2'd2
  } iopb_state_e;

  // byte offset of the bitmap offset word inside a 32-bit state segment
  localparam int unsigned MAP_OFS_FIELD = 102;
endpackage

// File: rtl/iopb_ctx.sv
module iopb_ctx #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned WORD_W = 16,
  parameter int unsigned LIM_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_start_i,
  input  logic [ADDR_W-1:0] ld_base_i,
  input  logic [ADDR_W-1:0] ld_limit_i,
  input  logic              ld_fin_i,
  input  logic [WORD_W-1:0] ofs_i,
  output logic [ADDR_W-1:0] map_addr_o,
  output logic [LIM_W-1:0]  map_lim_o
);
  logic [ADDR_W-1:0] seg_base_q, seg_lim_q, map_addr_q;
  logic [LIM_W-1:0]  map_lim_q;
  logic [ADDR_W-1:0] ofs_ext;
  logic              ofs_usable;

  assign ofs_ext    = ADDR_W'(ofs_i);
  assign ofs_usable = (ofs_i != '0) && (ofs_ext < seg_lim_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seg_base_q <= '0;
      seg_lim_q  <= '0;
      map_addr_q <= '0;
      map_lim_q  <= '0;
    end else if (ld_start_i) begin
      seg_base_q <= ld_base_i;
      seg_lim_q  <= ld_limit_i;
      map_lim_q  <= '0;
    end else if (ld_fin_i) begin
      if (ofs_usable) begin
        map_lim_q  <= LIM_W'(seg_lim_q - ofs_ext);
        map_addr_q <= seg_base_q + ofs_ext;
      end else begin
        map_lim_q  <= '0;
      end
    end
  end

  assign map_addr_o = map_addr_q;
  assign map_lim_o  = map_lim_q;
endmodule

// File: rtl/iopb_range.sv
module iopb_range #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned PORT_W = 16,
  parameter int unsigned LEN_W  = 3,
  parameter int unsigned WORD_W = 16,
  parameter int unsigned LIM_W  = 16
) (
  input  logic [PORT_W-1:0] port_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [LIM_W-1:0]  map_lim_i,
  input  logic [ADDR_W-1:0] map_addr_i,
  output logic              len_ok_o,
  output logic              range_ok_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic [WORD_W-1:0] mask_o
);
  localparam int unsigned SUM_W = PORT_W + 1;
  localparam int unsigned HI_W  = SUM_W - 3;

  logic [SUM_W-1:0]  end_sum;
  logic [HI_W-1:0]   end_idx;
  logic [WORD_W-1:0] ones;

  assign len_ok_o = (len_i == LEN_W'(1)) || (len_i == LEN_W'(2)) || (len_i == LEN_W'(4));

  // one extra bit so ports near the top do not wrap
  assign end_sum    = SUM_W'(port_i) + SUM_W'(len_i);
  assign end_idx    = end_sum[SUM_W-1:3];
  assign range_ok_o = (LIM_W + 1)'(end_idx) < (LIM_W + 1)'(map_lim_i);

  assign rd_addr_o = map_addr_i + ADDR_W'(port_i[PORT_W-1:3]);

  always_comb begin
    ones = '0;
    for (int i = 0; i < 4; i++) begin
      if (i < int'(len_i)) ones[i] = 1'b1;
    end
    mask_o = ones << port_i[2:0];
  end
endmodule

// File: rtl/iopb_seq.sv
module iopb_seq
  import iopb_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_req_i,
  input  logic              ld_wide_i,
  input  logic [ADDR_W-1:0] ld_base_i,
  input  logic              chk_req_i,
  input  logic              len_ok_i,
  input  logic              range_ok_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [WORD_W-1:0] mask_i,
  input  logic              mem_rvalid_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic              ready_o,
  output logic              ld_start_o,
  output logic              ld_fin_o,
  output logic              done_o,
  output logic              allow_o,
  output logic              fault_o,
  output logic              req_err_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o
);
  iopb_state_e       state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] mask_q;
  logic              done_q, allow_q, fault_q, rerr_q;
  logic              hit;

  assign ready_o    = (state_q == ST_IDLE);
  assign ld_start_o = ready_o && ld_req_i;
  assign ld_fin_o   = (state_q == ST_LD_WAIT) && mem_rvalid_i;
  assign hit        = |(mem_rdata_i & mask_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      mask_q  <= '0;
      done_q  <= 1'b0;
      allow_q <= 1'b0;
      fault_q <= 1'b0;
      rerr_q  <= 1'b0;
    end else begin
      done_q  <= 1'b0;
      allow_q <= 1'b0;
      fault_q <= 1'b0;
      rerr_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (ld_req_i) begin
            if (ld_wide_i) begin
              addr_q  <= ld_base_i + ADDR_W'(MAP_OFS_FIELD);
              state_q <= ST_LD_WAIT;
            end
          end else if (chk_req_i) begin
            if (!len_ok_i) begin
              done_q <= 1'b1;
              rerr_q <= 1'b1;
            end else if (!range_ok_i) begin
              done_q  <= 1'b1;
              fault_q <= 1'b1;
            end else begin
              addr_q  <= rd_addr_i;
              mask_q  <= mask_i;
              state_q <= ST_CK_WAIT;
            end
          end
        end
        ST_LD_WAIT: if (mem_rvalid_i) state_q <= ST_IDLE;
        ST_CK_WAIT: begin
          if (mem_rvalid_i) begin
            done_q  <= 1'b1;
            fault_q <= hit;
            allow_q <= !hit;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign done_o     = done_q;
  assign allow_o    = allow_q;
  assign fault_o    = fault_q;
  assign req_err_o  = rerr_q;
  assign mem_req_o  = !ready_o;
  assign mem_addr_o = addr_q;

  p_outcome_onehot_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $onehot({allow_o, fault_o, req_err_o}));
  p_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> !(allow_o || fault_o || req_err_o));
  p_badlen_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_req_i && ready_o && !ld_req_i && !len_ok_i) |=> (done_o && req_err_o && !mem_req_o));
  p_range_noread_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_req_i && ready_o && !ld_req_i && len_ok_i && !range_ok_i) |=> (done_o && fault_o && !mem_req_o));
  p_addr_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_rvalid_i) |=> (mem_req_o && $stable(mem_addr_o)));
  p_idle_noreq_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && !mem_rvalid_i) |=> !ready_o);
endmodule

// File: rtl/iopb_checker.sv
module iopb_checker #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned PORT_W = 16,
  parameter int unsigned LEN_W  = 3,
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_req_i,
  input  logic              ld_wide_i,
  input  logic [ADDR_W-1:0] ld_base_i,
  input  logic [ADDR_W-1:0] ld_limit_i,
  input  logic              chk_req_i,
  input  logic [PORT_W-1:0] chk_port_i,
  input  logic [LEN_W-1:0]  chk_len_i,
  output logic              ready_o,
  output logic              done_o,
  output logic              allow_o,
  output logic              fault_o,
  output logic              req_err_o,
  output logic [15:0]       err_code_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [WORD_W-1:0] mem_rdata_i
);
  localparam int unsigned LIM_W = PORT_W;

  logic              ld_start, ld_fin, len_ok, range_ok;
  logic [ADDR_W-1:0] map_addr, rd_addr;
  logic [LIM_W-1:0]  map_lim;
  logic [WORD_W-1:0] mask;

  iopb_ctx #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .LIM_W(LIM_W)) u_ctx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ld_start_i (ld_start),
    .ld_base_i  (ld_base_i),
    .ld_limit_i (ld_limit_i),
    .ld_fin_i   (ld_fin),
    .ofs_i      (mem_rdata_i),
    .map_addr_o (map_addr),
    .map_lim_o  (map_lim)
  );

  iopb_range #(.ADDR_W(ADDR_W), .PORT_W(PORT_W), .LEN_W(LEN_W), .WORD_W(WORD_W), .LIM_W(LIM_W)) u_range (
    .port_i     (chk_port_i),
    .len_i      (chk_len_i),
    .map_lim_i  (map_lim),
    .map_addr_i (map_addr),
    .len_ok_o   (len_ok),
    .range_ok_o (range_ok),
    .rd_addr_o  (rd_addr),
    .mask_o     (mask)
  );

  iopb_seq #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ld_req_i     (ld_req_i),
    .ld_wide_i    (ld_wide_i),
    .ld_base_i    (ld_base_i),
    .chk_req_i    (chk_req_i),
    .len_ok_i     (len_ok),
    .range_ok_i   (range_ok),
    .rd_addr_i    (rd_addr),
    .mask_i       (mask),
    .mem_rvalid_i (mem_rvalid_i),
    .mem_rdata_i  (mem_rdata_i),
    .ready_o      (ready_o),
    .ld_start_o   (ld_start),
    .ld_fin_o     (ld_fin),
    .done_o       (done_o),
    .allow_o      (allow_o),
    .fault_o      (fault_o),
    .req_err_o    (req_err_o),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o)
  );

  // a bitmap denial always carries a zero error code
  assign err_code_o = '0;
endmodule

// File: tb/iopb_checker_test.sv
module iopb_checker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_req = 1'b0, ld_wide = 1'b0;
  logic [31:0] ld_base = '0, ld_limit = '0;
  logic        chk_req = 1'b0;
  logic [15:0] chk_port = '0;
  logic [2:0]  chk_len = '0;
  logic        ready, done, allow, fault, req_err, mem_req;
  logic [15:0] err_code;
  logic [31:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [15:0] mem_rdata = '0;

  always #2 clk = ~clk;

  iopb_checker uut (
    .clk_i(clk), .rst_ni(rst_n),
    .ld_req_i(ld_req), .ld_wide_i(ld_wide), .ld_base_i(ld_base), .ld_limit_i(ld_limit),
    .chk_req_i(chk_req), .chk_port_i(chk_port), .chk_len_i(chk_len),
    .ready_o(ready), .done_o(done), .allow_o(allow), .fault_o(fault), .req_err_o(req_err),
    .err_code_o(err_code), .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // byte-addressed memory model
  logic [7:0] mem [int unsigned];
  function automatic logic [7:0] getb(int unsigned a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction
  function automatic logic [15:0] rd16(int unsigned a);
    return {getb(a + 1), getb(a)};
  endfunction

  int          rd_cnt = 0, lat_cnt = 0;
  logic [31:0] last_addr = '0;
  always @(negedge clk) begin
    if (mem_rvalid) mem_rvalid <= 1'b0;
    else if (rst_n && mem_req) begin
      if (lat_cnt == 2) begin
        lat_cnt    = 0;
        mem_rvalid <= 1'b1;
        mem_rdata  <= rd16(mem_addr);
        last_addr  = mem_addr;
        rd_cnt++;
      end else lat_cnt++;
    end
  end

  // reference state derived from the requirements
  logic [15:0] m_lim = '0;
  logic [31:0] m_addr = '0;

  typedef struct {
    int          kind;  // 0 allow, 1 fault, 2 req_err
    bit          need_rd;
    int          rd_before;
    int          issue;
    logic [31:0] addr;
    string       req;
  } item_t;
  item_t exp_q[$];

  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R11", "unexpected done", 1, 0);
      end else begin
        item_t it;
        int got;
        it  = exp_q.pop_front();
        got = allow ? 0 : fault ? 1 : req_err ? 2 : 3;
        check(got == it.kind, it.req, "result kind", got, it.kind);
        check($countones({allow, fault, req_err}) == 1, "R10", "outcome flags", {allow, fault, req_err}, 1);
        check(rd_cnt - it.rd_before == int'(it.need_rd), it.req, "memory reads", rd_cnt - it.rd_before, it.need_rd);
        if (it.need_rd) check(last_addr == it.addr, "R8", "read address", last_addr, it.addr);
        else check(cyc - it.issue == 1, it.req, "latency", cyc - it.issue, 1);
        if (fault) check(err_code == 16'h0, "R12", "error code", err_code, 0);
      end
    end
  end

  task automatic do_chk(int port, int len, string req);
    item_t it;
    it.need_rd = 1'b0;
    it.addr    = '0;
    it.req     = req;
    if (!(len == 1 || len == 2 || len == 4)) it.kind = 2;
    else if (((port + len) >> 3) >= int'(m_lim)) it.kind = 1;
    else begin
      logic [15:0] w, msk;
      it.need_rd = 1'b1;
      it.addr    = m_addr + 32'(port >> 3);
      w          = rd16(it.addr);
      msk        = 16'(((1 << len) - 1) << (port & 7));
      it.kind    = ((w & msk) != 0) ? 1 : 0;
    end
    while (!ready) @(negedge clk);
    chk_req      = 1'b1;
    chk_port     = 16'(port);
    chk_len      = 3'(len);
    it.rd_before = rd_cnt;
    it.issue     = cyc;
    exp_q.push_back(it);
    @(negedge clk);
    chk_req = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic do_load(bit wide, int unsigned base, int unsigned lim, int unsigned ofs, string req);
    int rb;
    mem[base + 102] = ofs[7:0];
    mem[base + 103] = ofs[15:8];
    if (wide && ofs[15:0] != 0 && ofs[15:0] < lim) begin
      m_lim  = 16'(lim - ofs[15:0]);
      m_addr = base + ofs[15:0];
    end else m_lim = '0;
    while (!ready) @(negedge clk);
    rb       = rd_cnt;
    ld_req   = 1'b1;
    ld_wide  = wide;
    ld_base  = base;
    ld_limit = lim;
    @(negedge clk);
    ld_req = 1'b0;
    while (!ready) @(negedge clk);
    check(rd_cnt - rb == int'(wide), req, "load reads", rd_cnt - rb, wide);
    if (wide) check(last_addr == base + 102, "R2", "offset read address", last_addr, base + 102);
  endtask

  initial begin
    int unsigned b;
    b = 32'h1000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(ready == 1'b1, "R1", "ready after reset", ready, 1);
    check(done == 1'b0 && mem_req == 1'b0, "R1", "idle outputs", {done, mem_req}, 0);
    do_chk(0, 1, "R1");

    // bitmap at b+0x68: byte1 = 0x81 (ports 8, 15), byte4 = 0x10 (port 36)
    mem[b + 32'h68 + 1] = 8'h81;
    mem[b + 32'h68 + 4] = 8'h10;
    do_load(1'b1, b, 32'h2067, 32'h68, "R3");
    do_chk(0, 1, "R9");
    do_chk(8, 1, "R9");
    do_chk(6, 2, "R9");
    do_chk(7, 2, "R9");   // spills into second byte
    do_chk(12, 4, "R9");
    do_chk(9, 4, "R9");
    do_chk(32, 4, "R9");
    do_chk(33, 4, "R9");
    do_chk(5, 3, "R6");
    do_chk(5, 0, "R6");
    do_chk(5, 7, "R6");

    // derived limit of 2 bytes
    do_load(1'b1, b, 32'h6A, 32'h68, "R3");
    do_chk(8, 4, "R7");
    do_chk(12, 4, "R7");
    do_chk(14, 1, "R7");
    do_chk(15, 1, "R7");

    // limit difference wraps to 8 in 16 bits
    do_load(1'b1, b, 32'h10070, 32'h68, "R3");
    do_chk(56, 1, "R3");
    do_chk(63, 1, "R3");

    // top of port space
    mem[b + 32'h68 + 32'h2000] = 8'h04;
    do_load(1'b1, b, 32'h3000, 32'h68, "R3");
    do_chk(16'hFFFC, 4, "R7");
    do_chk(16'hFFFF, 4, "R9");
    do_chk(16'hFFFF, 1, "R9");

    // unusable offsets
    do_load(1'b1, b, 32'h2067, 32'h0, "R4");
    do_chk(0, 1, "R4");
    do_load(1'b1, b, 32'h80, 32'h80, "R4");
    do_chk(0, 2, "R4");
    do_load(1'b1, b, 32'h80, 32'h90, "R4");
    do_chk(0, 4, "R4");
    do_load(1'b0, b, 32'h2067, 32'h68, "R5");
    do_chk(0, 1, "R5");

    // requests while busy are ignored (R11)
    do_load(1'b1, b, 32'h2067, 32'h68, "R11");
    begin
      item_t it;
      it.kind = 0; it.need_rd = 1'b1; it.addr = m_addr; it.req = "R11";
      while (!ready) @(negedge clk);
      chk_req = 1'b1; chk_port = 16'd0; chk_len = 3'd1;
      it.rd_before = rd_cnt; it.issue = cyc;
      exp_q.push_back(it);
      @(negedge clk);
      check(ready == 1'b0, "R11", "busy during read", ready, 0);
      chk_len = 3'd3; ld_req = 1'b1; ld_wide = 1'b0;
      @(negedge clk);
      chk_req = 1'b0; ld_req = 1'b0;
      while (exp_q.size() != 0) @(negedge clk);
      repeat (4) @(negedge clk);
    end
    do_chk(8, 1, "R11");   // limit kept: denied by bitmap, not by range

    // load and check together: load wins (R11)
    while (!ready) @(negedge clk);
    ld_req = 1'b1; ld_wide = 1'b0; chk_req = 1'b1; chk_len = 3'd7;
    m_lim = '0;
    @(negedge clk);
    ld_req = 1'b0; chk_req = 1'b0;
    repeat (4) @(negedge clk);
    do_chk(0, 1, "R11");

    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R10 watchdog actual=hang expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule